// File: doc/BRIEF.md
# ADC Serial Result Readout Port

This block is the slave-side output shifter of a serial data-acquisition converter when the host supplies the serial clock. The host pulls an active-low read frame low and toggles the serial clock. The block presents one serial data line, modelled as a data value plus an output enable, so a tri-state pad or a bench can form the high-impedance state. Each frame shifts out a 16-bit word: a leading zero, the 3-bit channel address, then the 12-bit conversion result. Data changes on rising serial-clock edges and the host samples it on falling edges.

The frame and serial clock are asynchronous to the block. Each passes through a two-flop synchroniser on a system clock at least four times faster than the serial clock, and edges are found by comparing successive samples. A conversion-done strobe captures the address and result together. If a frame is open when the strobe arrives, the new word waits in a pending register. It moves into the output register once the frame is high again, so a read in progress is never changed part-way through.

The shifter is a three-state machine. IDLE: the line is off. On a frame fall, the word is loaded and the machine goes to SHIFT if the serial clock is high, or to ARM if it is low. ARM: the line is still off. A serial-clock rise moves to SHIFT, and a frame rise returns to IDLE. SHIFT: the current bit is driven. Each serial-clock rise advances one bit. A rise after the last bit, or a frame rise, returns to IDLE.

Top module: `adc_rdout_port`

## Requirements
- R1: A frame carries 16 bits with word bit 15 sent first. Bit 15 is 0, bits 14:12 are the channel address (MSB first), and bits 11:0 are the result (MSB first).
- R2: The data value changes only after a rising serial-clock edge and holds steady across the following falling edge.
- R3: If the serial clock is high when the frame falls, the output enable asserts with the zero bit without waiting for a clock edge.
- R4: If the serial clock is low when the frame falls, the line stays disabled until the next rising serial-clock edge, which drives the zero bit.
- R5: The serial clock may pause for any length of time mid-frame without changing the bit sequence.
- R6: After the 16th bit, the output enable drops on the next rising serial-clock edge or on the frame going high, whichever comes first. It is never asserted while the frame is high.
- R7: A conversion-done strobe while no frame is open makes the new address and result appear in the next read.
- R8: A conversion-done strobe during an open frame leaves that read unchanged. The new word becomes readable only after the frame returns high.
- R9: A frame that rises before all 16 bits have been sent is abandoned, and the next frame starts again from the zero bit.
- R10: After reset the output enable is low and the output word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low read frame from the host (asynchronous) |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| conv_done | input | 1 | One-cycle strobe marking a finished conversion |
| conv_addr | input | 3 | Channel address of the finished conversion |
| conv_result | input | 12 | Result of the finished conversion |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for the serial data line |

## Verification
The bench starts frames with the serial clock both high and low. A design that ignores the clock level at the frame fall would send the zero bit one edge late and shift every later bit by one position. Strobes are injected mid-frame; a design without the hold-off would corrupt the low bits of the read in progress. Reads are abandoned part-way; a design that keeps the bit counter would resume mid-word on the next frame. Byte-sized clock pauses and both ways of ending a frame check that the line is released exactly once, and not one edge early.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_ARM   = 2'd1,
        RD_SHIFT = 2'd2
    } rd_state_t;
endpackage

// File: rtl/adc_rdout_sync.sv
module adc_rdout_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic meta_q, sync_q, prev_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[g];
                    sync_q <= RST_VAL[g];
                    prev_q <= RST_VAL[g];
                end else begin
                    meta_q <= async_i[g];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end
            assign lvl_o[g]  = sync_q;
            assign rise_o[g] = sync_q & ~prev_q;
            assign fall_o[g] = ~sync_q & prev_q;
        end
    endgenerate
endmodule

// File: rtl/adc_rdout_hold.sv
module adc_rdout_hold #(
    parameter int ADDR_W = 3,
    parameter int RES_W  = 12,
    localparam int WORD_W = 1 + ADDR_W + RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [RES_W-1:0]  res_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] out_q, pend_q;
    logic              pend_vld_q;
    logic [WORD_W-1:0] fresh;

    assign fresh = {1'b0, addr_i, res_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q      <= '0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else if (busy_i) begin
            if (done_i) begin
                pend_q     <= fresh;
                pend_vld_q <= 1'b1;
            end
        end else begin
            pend_vld_q <= 1'b0;
            if (done_i)
                out_q <= fresh;
            else if (pend_vld_q)
                out_q <= pend_q;
        end
    end

    assign word_o = out_q;
endmodule

// File: rtl/adc_rdout_fsm.sv
module adc_rdout_fsm
    import adc_rdout_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_lvl_i,
    input  logic              frame_fall_i,
    input  logic              sclk_lvl_i,
    input  logic              sclk_rise_i,
    input  logic [WORD_W-1:0] load_word_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    rd_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [WORD_W-1:0] sh_q, sh_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        unique case (state_q)
            RD_IDLE: begin
                if (frame_fall_i) begin
                    sh_d    = load_word_i;
                    cnt_d   = '0;
                    state_d = sclk_lvl_i ? RD_SHIFT : RD_ARM;
                end
            end
            RD_ARM: begin
                if (frame_lvl_i)
                    state_d = RD_IDLE;
                else if (sclk_rise_i)
                    state_d = RD_SHIFT;
            end
            RD_SHIFT: begin
                if (frame_lvl_i)
                    state_d = RD_IDLE;
                else if (sclk_rise_i) begin
                    if (cnt_q == LAST)
                        state_d = RD_IDLE;
                    else begin
                        sh_d  = {sh_q[WORD_W-2:0], 1'b0};
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        sdo_oe_o = (state_q == RD_SHIFT);
        sdo_o    = sdo_oe_o & sh_q[WORD_W-1];
    end
endmodule

// File: rtl/adc_rdout_port.sv
module adc_rdout_port #(
    parameter int ADDR_W = 3,
    parameter int RES_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              sclk,
    input  logic              conv_done,
    input  logic [ADDR_W-1:0] conv_addr,
    input  logic [RES_W-1:0]  conv_result,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int WORD_W = 1 + ADDR_W + RES_W;

    logic [1:0]        lvl, rise, fall;
    logic              frame_s, frame_fall, sclk_s, sclk_rise;
    logic [WORD_W-1:0] out_word;

    adc_rdout_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk, frame_n}),
        .lvl_o   (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign frame_s    = lvl[0];
    assign frame_fall = fall[0];
    assign sclk_s     = lvl[1];
    assign sclk_rise  = rise[1];

    adc_rdout_hold #(.ADDR_W(ADDR_W), .RES_W(RES_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (~frame_s),
        .done_i (conv_done),
        .addr_i (conv_addr),
        .res_i  (conv_result),
        .word_o (out_word)
    );

    adc_rdout_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_lvl_i  (frame_s),
        .frame_fall_i (frame_fall),
        .sclk_lvl_i   (sclk_s),
        .sclk_rise_i  (sclk_rise),
        .load_word_i  (out_word),
        .sdo_o        (sdo),
        .sdo_oe_o     (sdo_oe)
    );
endmodule

// File: rtl/adc_rdout_port_chk.sv
module adc_rdout_port_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_s,
    input logic              sclk_rise,
    input logic              sdo,
    input logic              sdo_oe,
    input logic [WORD_W-1:0] out_word
);
    p_first_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sdo);

    p_change_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$past(sclk_rise)) |-> $stable(sdo));

    p_off_frame_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_s && $past(frame_s)) |-> !sdo_oe);

    p_hold_during_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_s && !$past(frame_s)) |-> $stable(out_word));
endmodule

bind adc_rdout_port adc_rdout_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_s   (frame_s),
    .sclk_rise (sclk_rise),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .out_word  (out_word)
);

// File: tb/tb_adc_rdout_port.sv
module tb_adc_rdout_port;
    localparam int H = 6;

    logic        clk = 0, rst_n = 0;
    logic        frame_n = 1, sclk = 0, conv_done = 0;
    logic [2:0]  conv_addr = '0;
    logic [11:0] conv_result = '0;
    logic        sdo, sdo_oe;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    logic [15:0] cur_w = '0, pend_w = '0;
    bit pend = 0;
    string next_tag = "R10";

    always #4 clk = ~clk;

    adc_rdout_port dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk),
        .conv_done(conv_done), .conv_addr(conv_addr), .conv_result(conv_result),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] mk_word(input logic [2:0] a, input logic [11:0] r);
        return {1'b0, a, r};
    endfunction

    task automatic strobe(input logic [2:0] a, input logic [11:0] r);
        conv_addr = a; conv_result = r; conv_done = 1;
        step(1);
        conv_done = 0;
        if (frame_n) begin
            cur_w = mk_word(a, r);
            next_tag = "R7";
        end else begin
            pend_w = mk_word(a, r);
            pend = 1;
        end
    endtask

    task automatic do_read(input bit hi, input int nb, input bit inj, input bit end_by_clk, input int gap);
        logic [15:0] w;
        string tag;
        w = cur_w;
        tag = next_tag;
        next_tag = "R1";
        sclk = hi; step(H);
        frame_n = 0; step(H);
        if (hi)
            chk(sdo_oe && !sdo, "R3", {14'b0, sdo_oe, sdo}, 16'h0002);
        else
            chk(!sdo_oe, "R4", {15'b0, sdo_oe}, 16'h0000);
        for (int i = 0; i < nb; i++) begin
            if (!(hi && i == 0)) begin
                if (sclk) begin sclk = 0; step(H + ((i == 8) ? gap : 0)); end
                sclk = 1; step(H);
            end
            chk(sdo_oe && (sdo == w[15-i]),
                (i == 0 && !hi) ? "R4" : (i == 8 && gap > 0) ? "R5" : (inj && i > 7) ? "R8" : tag,
                {14'b0, sdo_oe, sdo}, {14'b0, 1'b1, w[15-i]});
            if (inj && i == 7) strobe(3'($urandom), 12'($urandom));
        end
        if (nb == 16) begin
            sclk = 0; step(H);
            chk(sdo_oe && (sdo == w[0]), "R2", {14'b0, sdo_oe, sdo}, {14'b0, 1'b1, w[0]});
            if (end_by_clk) begin
                sclk = 1; step(H);
                chk(!sdo_oe, "R6", {15'b0, sdo_oe}, 16'h0000);
            end
            frame_n = 1; step(H);
            chk(!sdo_oe, "R6", {15'b0, sdo_oe}, 16'h0000);
        end else begin
            frame_n = 1; step(H);
            chk(!sdo_oe, "R9", {15'b0, sdo_oe}, 16'h0000);
            next_tag = "R9";
        end
        sclk = 0; step(H);
        if (pend) begin
            cur_w = pend_w; pend = 0;
            next_tag = "R8";
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        rst_n = 1;
        step(2);
        chk(!sdo_oe, "R10", {15'b0, sdo_oe}, 16'h0000);
        do_read(0, 16, 0, 1, 0);
        strobe(3'b101, 12'hA5C);
        do_read(1, 16, 0, 1, 0);
        strobe(3'b010, 12'h3F1);
        do_read(0, 16, 0, 0, 20);
        do_read(1, 16, 1, 1, 0);
        do_read(0, 16, 0, 1, 0);
        do_read(1, 5, 0, 1, 0);
        do_read(0, 16, 0, 1, 0);
        for (int k = 0; k < 40; k++) begin
            if ($urandom_range(2, 0) == 0) strobe(3'($urandom), 12'($urandom));
            do_read(1'($urandom), ($urandom_range(4, 0) == 0) ? int'($urandom_range(15, 1)) : 16,
                    ($urandom_range(3, 0) == 0), 1'($urandom),
                    ($urandom_range(1, 0) == 1) ? int'($urandom_range(30, 1)) : 0);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule